// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the master side of a 16-bit processor-style external bus. The low 16 lines carry a 20-bit address and the data in turn. The top 4 lines carry the high address bits and then status bits. A client hands over one request at a time: an address, a write flag, an IO flag, an upper-byte enable, a 2-bit segment code and write data. The block then runs one bus cycle. First comes an address phase marked by a latch strobe. Next is a data phase with an active-low read or write strobe, a buffer direction output and an active-low buffer enable. The phase is stretched by wait states while the responder holds `ready` low, and the cycle ends with a release state.

An external DMA master can take the bus with `hold`. The sequencer lets the running cycle finish and starts no new one. It then marks every bus output as undriven and raises `hlda`. Tri-state is modelled with separate output-enable signals. After a qualified reset, the sequencer first runs a memory read at the restart address FFFF0h on its own, and only then accepts client requests.

Top module: `mux_bus_seq`

## Requirements
- R1: In the cycle after a request is accepted (first state), `ale`=1 and `ad_oe`=1. `ad_out` carries address bits 15..0 and `as_out` carries bits 19..16. `mio`=1 for a memory cycle (`req_io`=0) and 0 for IO, `bhe_n`=!`req_bhe`, `dtr`=`req_write`, and every strobe is inactive.
- R2: From the second state through the fourth state, `as_out` holds the status value {2'b00, seg}. Bits 1..0 are the segment code given with the request. `ale` is 0 in these states.
- R3: In a read cycle, `rd_n` and `den_n` are 0 in the second and third states and in every wait state, and `ad_oe` is 0. `rdata` takes `ad_in` as sampled at the clock edge that ends the last strobe state. `done` is 1 for the one cycle after the fourth state.
- R4: In a write cycle, `wr_n` is 0 in the same window as the read strobe in R3. `ad_oe`=1 and `ad_out` equals the write data from the second state through the fourth state.
- R5: When `ready` is 0 at the edge that ends the third state or a wait state, a wait state follows with all strobes and lines unchanged. When `ready` is 1 there, the fourth state follows. A cycle with N wait states lasts 4+N clocks.
- R6: In the fourth state `rd_n`, `wr_n` and `den_n` are 1. `rd_n` and `wr_n` are never 0 together, and no strobe is 0 while `ale` is 1.
- R7: When `hold` is 1 at a cycle boundary (idle or fourth state), the next cycle has `hlda`=1, `bus_oe`=0 and `ad_oe`=0, with `req_ready`=0. `hlda` returns to 0 one clock after `hold` is seen at 0.
- R8: When `hold` rises during a cycle, that cycle completes unchanged with `hlda`=0. `hlda` rises in the cycle right after the fourth state.
- R9: When `hold` and a request are both present at a boundary, hold wins. The request is not accepted and is taken after hold is released.
- R10: While `rst` has been 1 for at least RST_MIN (4) consecutive clocks, strobes are inactive, `ale`=0, `hlda`=0 and `req_ready`=0. The first cycle after release is a memory read of FFFF0h with segment code 2'b10 and the upper byte enabled.
- R11: A `rst` pulse shorter than RST_MIN clocks has no effect. No restart read is started, and `req_ready` stays 1 in idle.
- R12: `req_ready` is 1 only in idle or the fourth state, with `hold`=0 and the restart read already issued. It is 0 in the first, second, third and wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, qualified after RST_MIN clocks |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Request accepted at this clock edge when valid |
| req_addr | input | 20 | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = IO port, 0 = memory |
| req_bhe | input | 1 | 1 = upper data byte takes part |
| req_seg | input | 2 | Segment code put on the status lines |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle pulse after a cycle ends |
| rdata | output | 16 | Data captured by the last read |
| ad_out | output | 16 | Shared address/data lines, driven value |
| ad_in | input | 16 | Shared address/data lines, received value |
| ad_oe | output | 1 | Shared lines driven when 1 |
| as_out | output | 4 | High address / status lines |
| bus_oe | output | 1 | Enable for high lines and control outputs (0 = high impedance) |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| den_n | output | 1 | Data buffer enable, active low |
| dtr | output | 1 | Buffer direction, 1 = transmit |
| mio | output | 1 | 1 = memory, 0 = IO |
| bhe_n | output | 1 | Upper byte enable, active low |
| ready | input | 1 | Responder ready; 0 inserts wait states |
| hold | input | 1 | External bus request |
| hlda | output | 1 | Bus handed over |

## Verification
A wrong state register shows on the pins within one clock. Every output is registered straight from the next-state decode, so a skipped or repeated state moves `ale`, a strobe or `ad_oe` at the first edge after the fault. The checks compare each state's pins against the cycle length the bench computes from the number of low `ready` samples. A corrupted latched request shows in the address or status lines of the next state. A fault in the hold path shows as `hlda` rising while a strobe is active, or a cycle being cut short. A fault in the reset path shows as a missing or spurious restart read at FFFF0h.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  localparam int AW   = 20;
  localparam int DW   = 16;
  localparam int HW   = AW - DW;
  localparam int SEGW = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4, S_HOLD
  } mbs_st_e;

  typedef struct packed {
    logic [AW-1:0]   addr;
    logic            wr;
    logic            io;
    logic            bhe;
    logic [SEGW-1:0] seg;
    logic [DW-1:0]   wdata;
  } mbs_req_t;

  function automatic logic is_strobe(input mbs_st_e s);
    return (s == S_T2) || (s == S_T3) || (s == S_TW);
  endfunction

  function automatic logic is_cycle(input mbs_st_e s);
    return (s == S_T1) || is_strobe(s) || (s == S_T4);
  endfunction

  function automatic logic [HW-1:0] status_bits(input logic [SEGW-1:0] seg);
    return {{(HW-SEGW){1'b0}}, seg};
  endfunction
endpackage

// File: rtl/mbs_rst_filt.sv
module mbs_rst_filt #(
  parameter int MIN_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  output logic srst
);
  generate
    if (MIN_CYC > 1) begin : g_filt
      logic [MIN_CYC-2:0] hist;
      always_ff @(posedge clk) begin
        hist[0] <= rst;
        for (int i = 1; i < MIN_CYC - 1; i++) hist[i] <= hist[i-1];
      end
      assign srst = rst & (&hist);
    end else begin : g_pass
      assign srst = rst;
    end
  endgenerate
endmodule

// File: rtl/mbs_fsm.sv
module mbs_fsm
  import mbs_pkg::*;
(
  input  logic          clk,
  input  logic          srst,
  input  logic          hold,
  input  logic          ready,
  input  logic          req_valid,
  input  mbs_req_t      req,
  input  mbs_req_t      boot,
  input  logic [DW-1:0] ad_in,
  output mbs_st_e       st_d,
  output mbs_req_t      cur_d,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rdata
);
  mbs_st_e  st_q;
  mbs_req_t cur_q;
  logic     boot_pend;
  logic     boundary;
  logic     boot_take;

  always_comb begin
    st_d      = st_q;
    cur_d     = cur_q;
    boundary  = (st_q == S_IDLE) || (st_q == S_T4);
    req_ready = boundary && !hold && !boot_pend;
    boot_take = boundary && !hold && boot_pend;
    case (st_q)
      S_IDLE, S_T4: begin
        if (hold) st_d = S_HOLD;
        else if (boot_pend) begin
          st_d  = S_T1;
          cur_d = boot;
        end else if (req_valid) begin
          st_d  = S_T1;
          cur_d = req;
        end else st_d = S_IDLE;
      end
      S_T1:       st_d = S_T2;
      S_T2:       st_d = S_T3;
      S_T3, S_TW: st_d = ready ? S_T4 : S_TW;
      S_HOLD:     st_d = hold ? S_HOLD : S_IDLE;
      default:    st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      st_q      <= S_IDLE;
      cur_q     <= '0;
      boot_pend <= 1'b1;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      st_q  <= st_d;
      cur_q <= cur_d;
      if (boot_take) boot_pend <= 1'b0;
      done <= (st_q == S_T4);
      if ((st_q == S_T3 || st_q == S_TW) && ready && !cur_q.wr) rdata <= ad_in;
    end
  end
endmodule

// File: rtl/mbs_pins.sv
module mbs_pins
  import mbs_pkg::*;
(
  input  logic          clk,
  input  logic          srst,
  input  mbs_st_e       st_d,
  input  mbs_req_t      cur_d,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [HW-1:0] as_out,
  output logic          bus_oe,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic          den_n,
  output logic          dtr,
  output logic          mio,
  output logic          bhe_n,
  output logic          hlda
);
  logic          in_cyc, strb;
  logic          ale_d, rd_n_d, wr_n_d, den_n_d, ad_oe_d, mio_d, bhe_n_d, dtr_d, hlda_d;
  logic [DW-1:0] ad_d;
  logic [HW-1:0] as_d;

  always_comb begin
    in_cyc  = is_cycle(st_d);
    strb    = is_strobe(st_d);
    ale_d   = (st_d == S_T1);
    rd_n_d  = !(strb && !cur_d.wr);
    wr_n_d  = !(strb && cur_d.wr);
    den_n_d = !strb;
    ad_oe_d = ale_d || (cur_d.wr && (strb || st_d == S_T4));
    if (ale_d)        ad_d = cur_d.addr[DW-1:0];
    else if (ad_oe_d) ad_d = cur_d.wdata;
    else              ad_d = '0;
    if (ale_d)        as_d = cur_d.addr[AW-1:DW];
    else if (in_cyc)  as_d = status_bits(cur_d.seg);
    else              as_d = '0;
    mio_d   = in_cyc && !cur_d.io;
    bhe_n_d = !(in_cyc && cur_d.bhe);
    dtr_d   = in_cyc && cur_d.wr;
    hlda_d  = (st_d == S_HOLD);
  end

  always_ff @(posedge clk) begin
    if (srst) begin
      ad_out <= '0;
      ad_oe  <= 1'b0;
      as_out <= '0;
      bus_oe <= 1'b1;
      ale    <= 1'b0;
      rd_n   <= 1'b1;
      wr_n   <= 1'b1;
      den_n  <= 1'b1;
      dtr    <= 1'b0;
      mio    <= 1'b0;
      bhe_n  <= 1'b1;
      hlda   <= 1'b0;
    end else begin
      ad_out <= ad_d;
      ad_oe  <= ad_oe_d && !hlda_d;
      as_out <= as_d;
      bus_oe <= !hlda_d;
      ale    <= ale_d;
      rd_n   <= rd_n_d;
      wr_n   <= wr_n_d;
      den_n  <= den_n_d;
      dtr    <= dtr_d;
      mio    <= mio_d;
      bhe_n  <= bhe_n_d;
      hlda   <= hlda_d;
    end
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int              RST_MIN   = 4,
  parameter logic [AW-1:0]   RESET_VEC = 20'hFFFF0,
  parameter logic [SEGW-1:0] BOOT_SEG  = 2'b10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [AW-1:0]   req_addr,
  input  logic            req_write,
  input  logic            req_io,
  input  logic            req_bhe,
  input  logic [SEGW-1:0] req_seg,
  input  logic [DW-1:0]   req_wdata,
  output logic            done,
  output logic [DW-1:0]   rdata,
  output logic [DW-1:0]   ad_out,
  input  logic [DW-1:0]   ad_in,
  output logic            ad_oe,
  output logic [HW-1:0]   as_out,
  output logic            bus_oe,
  output logic            ale,
  output logic            rd_n,
  output logic            wr_n,
  output logic            den_n,
  output logic            dtr,
  output logic            mio,
  output logic            bhe_n,
  input  logic            ready,
  input  logic            hold,
  output logic            hlda
);
  logic     srst;
  mbs_req_t req, boot, cur_d;
  mbs_st_e  st_d;

  assign req  = '{addr: req_addr, wr: req_write, io: req_io, bhe: req_bhe,
                  seg: req_seg, wdata: req_wdata};
  assign boot = '{addr: RESET_VEC, wr: 1'b0, io: 1'b0, bhe: 1'b1,
                  seg: BOOT_SEG, wdata: '0};

  mbs_rst_filt #(.MIN_CYC(RST_MIN)) u_rst (
    .clk(clk), .rst(rst), .srst(srst)
  );

  mbs_fsm u_fsm (
    .clk(clk), .srst(srst), .hold(hold), .ready(ready),
    .req_valid(req_valid), .req(req), .boot(boot), .ad_in(ad_in),
    .st_d(st_d), .cur_d(cur_d), .req_ready(req_ready),
    .done(done), .rdata(rdata)
  );

  mbs_pins u_pins (
    .clk(clk), .srst(srst), .st_d(st_d), .cur_d(cur_d),
    .ad_out(ad_out), .ad_oe(ad_oe), .as_out(as_out), .bus_oe(bus_oe),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dtr(dtr),
    .mio(mio), .bhe_n(bhe_n), .hlda(hlda)
  );
endmodule

// File: rtl/mbs_chk.sv
module mbs_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          ale,
  input logic          rd_n,
  input logic          wr_n,
  input logic          ad_oe,
  input logic          bus_oe,
  input logic          hlda,
  input logic          ready,
  input logic [DW-1:0] ad_out
);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(!rd_n && !wr_n));
  // R6
  ale_no_strobe_chk: assert property (@(posedge clk) disable iff (rst) ale |-> (rd_n && wr_n));
  // R3
  read_lines_in_chk: assert property (@(posedge clk) disable iff (rst) !rd_n |-> !ad_oe);
  // R7
  hold_float_chk: assert property (@(posedge clk) disable iff (rst) hlda |-> (!bus_oe && !ad_oe));
  // R8
  hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hlda) |-> ($past(rd_n) && $past(wr_n) && !$past(ale)));
  // R5
  wait_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !ready) |=> !rd_n);
  // R4
  wdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> $stable(ad_out));
  // R1
  ale_single_chk: assert property (@(posedge clk) disable iff (rst) ale |=> !ale);
endmodule

bind mux_bus_seq mbs_chk #(.DW(mbs_pkg::DW)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe),
  .bus_oe(bus_oe), .hlda(hlda), .ready(ready), .ad_out(ad_out)
);

// File: tb/tb_mux_bus_seq.sv
module tb_mux_bus_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst, req_valid, req_ready, req_write, req_io, req_bhe;
  logic [19:0] req_addr;
  logic [1:0]  req_seg;
  logic [15:0] req_wdata, rdata, ad_out, ad_in;
  logic        done, ad_oe, bus_oe, ale, rd_n, wr_n, den_n, dtr, mio, bhe_n;
  logic        ready, hold, hlda;
  logic [3:0]  as_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_seq dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_io(req_io),
    .req_bhe(req_bhe), .req_seg(req_seg), .req_wdata(req_wdata),
    .done(done), .rdata(rdata), .ad_out(ad_out), .ad_in(ad_in),
    .ad_oe(ad_oe), .as_out(as_out), .bus_oe(bus_oe), .ale(ale),
    .rd_n(rd_n), .wr_n(wr_n), .den_n(den_n), .dtr(dtr), .mio(mio),
    .bhe_n(bhe_n), .ready(ready), .hold(hold), .hlda(hlda)
  );

  function automatic logic [15:0] memval(input logic [19:0] a);
    return a[15:0] ^ {a[19:16], 12'h5A3};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic strobe_checks(input logic wr, input logic [1:0] seg, input logic [15:0] wd);
    chk("R2 ale low", ale, 0);
    chk("R2 status", as_out, {2'b00, seg});
    chk("R3 rd_n", rd_n, wr);
    chk("R4 wr_n", wr_n, !wr);
    chk("R3 den_n", den_n, 0);
    chk("R3/R4 ad_oe", ad_oe, wr);
    if (wr) chk("R4 wdata", ad_out, wd);
    chk("R12 no ready", req_ready, 0);
  endtask

  // entry: at the negedge of the first state
  task automatic cycle_body(input logic [19:0] a, input logic wr, input logic io,
                            input logic bhe, input logic [1:0] seg, input logic [15:0] wd,
                            input int nwait, input bit hold_mid);
    chk("R1 ale", ale, 1);
    chk("R1 ad_oe", ad_oe, 1);
    chk("R1 addr lo", ad_out, a[15:0]);
    chk("R1 addr hi", as_out, a[19:16]);
    chk("R1 mio", mio, !io);
    chk("R1 bhe_n", bhe_n, !bhe);
    chk("R1 dtr", dtr, wr);
    chk("R1 strobes", {rd_n, wr_n, den_n}, 3'b111);
    chk("R12 no ready", req_ready, 0);
    ad_in = memval(a);
    @(negedge clk);
    strobe_checks(wr, seg, wd);
    ready = (nwait == 0);
    if (hold_mid) hold = 1'b1;
    @(negedge clk);
    strobe_checks(wr, seg, wd);
    chk("R8 no hlda", hlda, 0);
    for (int w = 0; w < nwait; w++) begin
      @(negedge clk);
      strobe_checks(wr, seg, wd);
      chk("R5 wait state", {mio, bhe_n}, {!io, !bhe});
      ready = (w == nwait - 1);
    end
    @(negedge clk);
    chk("R6 released", {rd_n, wr_n, den_n}, 3'b111);
    chk("R2 status T4", as_out, {2'b00, seg});
    chk("R4 ad_oe T4", ad_oe, wr);
    if (wr) chk("R4 wdata T4", ad_out, wd);
    chk("R8 no hlda T4", hlda, 0);
    chk("R5 not done yet", done, 0);
    ready = 1'b1;
    @(negedge clk);
    chk("R3 done", done, 1);
    if (!wr) chk("R3 rdata", rdata, memval(a));
    if (hold_mid) begin
      chk("R8 hlda", hlda, 1);
      chk("R8 bus_oe", bus_oe, 0);
      chk("R7 ad_oe", ad_oe, 0);
      hold = 1'b0;
      @(negedge clk);
      chk("R7 hlda drop", hlda, 0);
    end
  endtask

  task automatic run_cycle(input logic [19:0] a, input logic wr, input logic io,
                           input logic bhe, input logic [1:0] seg, input logic [15:0] wd,
                           input int nwait, input bit hold_mid);
    req_addr = a; req_write = wr; req_io = io; req_bhe = bhe;
    req_seg = seg; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cycle_body(a, wr, io, bhe, seg, wd, nwait, hold_mid);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_io = 1'b0;
    req_bhe = 1'b0; req_seg = '0; req_wdata = '0; ad_in = '0; ready = 1'b1; hold = 1'b0;
    r = $urandom(32'h00C0FFEE);
    repeat (5) @(negedge clk);
    // R10 reset state
    chk("R10 ale", ale, 0);
    chk("R10 strobes", {rd_n, wr_n, den_n}, 3'b111);
    chk("R10 hlda", hlda, 0);
    chk("R10 req_ready", req_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    // R10 restart read
    cycle_body(20'hFFFF0, 1'b0, 1'b0, 1'b1, 2'b10, 16'h0, 0, 0);
    // R11 short pulse
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 req_ready", req_ready, 1);
    chk("R11 no boot ale", ale, 0);
    @(negedge clk);
    chk("R11 still idle", ale, 0);
    // directed
    run_cycle(20'h12345, 1'b0, 1'b0, 1'b1, 2'b01, 16'h0, 0, 0);
    run_cycle(20'hABCDE, 1'b1, 1'b0, 1'b0, 2'b11, 16'hBEEF, 2, 0);
    run_cycle(20'h00F0A, 1'b0, 1'b1, 1'b0, 2'b00, 16'h0, 3, 0);
    run_cycle(20'h54321, 1'b1, 1'b1, 1'b1, 2'b10, 16'h1357, 1, 1);
    // R9 tie between hold and request
    @(negedge clk);
    hold = 1'b1; req_valid = 1'b1; req_addr = 20'h6789A; req_write = 1'b0;
    req_io = 1'b0; req_bhe = 1'b1; req_seg = 2'b01; req_wdata = '0;
    @(negedge clk);
    chk("R9 hold wins", hlda, 1);
    chk("R9 no ale", ale, 0);
    chk("R7 req_ready", req_ready, 0);
    chk("R7 bus_oe", bus_oe, 0);
    @(negedge clk);
    chk("R7 hold kept", hlda, 1);
    hold = 1'b0;
    @(negedge clk);
    chk("R7 released", hlda, 0);
    chk("R9 pending", ale, 0);
    @(negedge clk);
    req_valid = 1'b0;
    cycle_body(20'h6789A, 1'b0, 1'b0, 1'b1, 2'b01, 16'h0, 0, 0);
    // random
    for (int k = 0; k < 40; k++) begin
      r = $urandom;
      run_cycle($urandom, r[0], r[1], r[2], r[4:3], $urandom, int'(r[6:5]), r[9:7] == 3'd0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule